// File: doc/BRIEF.md
# Prescaled Interval Timer Counter

This peripheral holds up to three independent 16-bit counter channels behind a plain register bus. The bus has a valid strobe, a write flag, a byte address and a write-data word. Writes take effect at the clock edge. Read data is driven combinationally in the same cycle as the request. Each channel has six registers: clock setup, counter control, live count, interval limit, event status and event enable. The copies of a given register for the different channels sit one 32-bit word apart.

A channel counts either every core clock or only in cycles where the shared `ext_tick` strobe is high, depending on its source-select bit. A power-of-two prescaler can sit in front of the counter. In free-running mode the counter wraps from 0xFFFF to 0 and records an overflow. In interval mode it counts from 0 up to the programmed limit, returns to 0 and records an interval event. Each recorded event sets a status flag that stays until software reads the status register. Each channel drives a level interrupt that is high while any enabled flag is set.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter-control register reads 0x01 (halted), every other register reads 0, and every irq bit is 0.
- R2: The register bases for channel 0 are: clock setup 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54, enable 0x60. Channel n sits at base + 4n. A read of any other address, including a non-word-aligned one, returns 0.
- R3: When counter-control bit 0 (halt) is 0, the count rises by one on every qualified tick. While halt is 1, the count and the prescaler phase keep their values.
- R4: Clock-setup bit 0 enables the prescaler, and bits 4:1 hold an exponent P. With the prescaler on, the counter steps once per 2^(P+1) qualified ticks. With it off, the counter steps on every qualified tick.
- R5: Clock-setup bit 5 selects the tick source. 0 means every clock, 1 means only cycles with `ext_tick` high. The bit reads back as written.
- R6: Writing counter control with bit 4 set zeroes the count and the prescaler phase in that cycle. This happens even if the same write clears halt. Bit 4 always reads back as 0. Bits 0, 1 and 5 read back as written.
- R7: When counter-control bit 1 (interval mode) is set, a step taken with the count at or above the interval register takes the count to 0 and sets status bit 0.
- R8: When interval mode is off, a step taken at count 0xFFFF wraps the count to 0 and sets status bit 4.
- R9: A status read returns the pending flags and clears them. An event that arrives in the same cycle as the read stays pending.
- R10: irq[n] is high exactly when (status & enable) of channel n is non-zero. The enable bits are bit 0 (interval) and bit 4 (overflow).
- R11: Writes to the count and status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick | input | 1 | Alternate tick qualifier shared by all channels |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The bench drives the prescaler at a non-zero exponent and from the external source. A design with an off-by-one divisor, or one that ignores the qualifier, drifts away from the model within a few steps. It reads status in every cycle while interval events land on some of those reads. A design that lets the clear win would drop an interrupt. It restarts a halted channel with a single write that sets the reset bit and clears halt. A design that honours only one of the two would hold the wrong count. A free-running channel is taken across 0xFFFF, and writes to read-only registers are checked for effect.

// File: rtl/itm_pkg.sv
`timescale 1ns/1ps
package itm_pkg;

  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_CLK  = 3'd1,
    RK_CTL  = 3'd2,
    RK_VAL  = 3'd3,
    RK_LIM  = 3'd4,
    RK_STS  = 3'd5,
    RK_ENA  = 3'd6
  } reg_kind_e;

  localparam int NUM_KINDS = 6;

  // bit positions that software depends on
  localparam int CTL_HALT_BIT  = 0;
  localparam int CTL_IMODE_BIT = 1;
  localparam int CTL_RST_BIT   = 4;
  localparam int CTL_AUX_BIT   = 5;
  localparam int EVT_IVL_BIT   = 0;
  localparam int EVT_OVF_BIT   = 4;

  typedef struct packed {
    logic       src_sel;
    logic [3:0] pexp;
    logic       pre_en;
  } clk_cfg_t;

  typedef struct packed {
    logic aux;
    logic imode;
    logic halt;
  } ctl_cfg_t;

  function automatic logic [7:0] kind_base(reg_kind_e k);
    case (k)
      RK_CLK:  return 8'h00;
      RK_CTL:  return 8'h0C;
      RK_VAL:  return 8'h18;
      RK_LIM:  return 8'h24;
      RK_STS:  return 8'h54;
      RK_ENA:  return 8'h60;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/itm_addr_decode.sv
`timescale 1ns/1ps
module itm_addr_decode
  import itm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [CH_W-1:0]   ch
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_CH);

  always_comb begin
    kind = RK_NONE;
    ch   = '0;
    for (int k = 1; k <= NUM_KINDS; k++) begin
      logic [ADDR_W-1:0] diff;
      diff = addr - ADDR_W'(kind_base(reg_kind_e'(k)));
      if (diff < SPAN && diff[1:0] == 2'b00) begin
        kind = reg_kind_e'(k);
        ch   = CH_W'(diff >> 2);
      end
    end
  end

  // R2: only word-aligned addresses ever select a register
  a_r2_aligned_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != RK_NONE) |-> (addr[1:0] == 2'b00));

endmodule

// File: rtl/itm_prescale.sv
`timescale 1ns/1ps
module itm_prescale #(
  parameter int EXP_W = 4,
  localparam int PS_W = 1 << EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_tick,
  input  logic             pre_en,
  input  logic [EXP_W-1:0] pexp,
  input  logic             restart,
  output logic             step
);

  logic [PS_W-1:0] phase_q, phase_d;
  logic [PS_W-1:0] limit;
  logic            qual;
  logic            at_end;

  assign limit  = {PS_W{1'b1}} >> (~pexp);
  assign qual   = run & src_tick;
  assign at_end = (phase_q >= limit);
  assign step   = qual & (~pre_en | at_end);

  always_comb begin
    phase_d = phase_q;
    if (restart || !pre_en) begin
      phase_d = '0;
    end else if (qual) begin
      phase_d = at_end ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R3: a halted channel never steps
  a_r3_no_step_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !step);

  // R6: restart clears the prescaler phase
  a_r6_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));

endmodule

// File: rtl/itm_channel.sv
`timescale 1ns/1ps
module itm_channel
  import itm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              wr_clk,
  input  logic              wr_ctl,
  input  logic              wr_lim,
  input  logic              wr_ena,
  input  logic              rd_sts,
  input  logic [CNT_W-1:0]  wdata,
  input  reg_kind_e         rd_kind,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  clk_cfg_t         clk_cfg_q, clk_cfg_d;
  ctl_cfg_t         ctl_cfg_q, ctl_cfg_d;
  logic [CNT_W-1:0] limit_q, limit_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [1:0]       ena_q, ena_d;   // [0]=interval, [1]=overflow
  logic [1:0]       sts_q, sts_d;

  logic restart, step, src_tick, evt_ivl, evt_ovf, at_limit;

  assign restart  = wr_ctl & wdata[CTL_RST_BIT];
  assign src_tick = clk_cfg_q.src_sel ? ext_tick : 1'b1;

  itm_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (~ctl_cfg_q.halt),
    .src_tick (src_tick),
    .pre_en   (clk_cfg_q.pre_en),
    .pexp     (clk_cfg_q.pexp),
    .restart  (restart),
    .step     (step)
  );

  assign at_limit = (count_q >= limit_q);
  assign evt_ivl  = step & ~restart & ctl_cfg_q.imode & at_limit;
  assign evt_ovf  = step & ~restart & ~ctl_cfg_q.imode & (&count_q);

  // counter next state
  always_comb begin
    count_d = count_q;
    if (restart) begin
      count_d = '0;
    end else if (step) begin
      if (ctl_cfg_q.imode && at_limit) count_d = '0;
      else                             count_d = count_q + 1'b1;
    end
  end

  // configuration next state
  always_comb begin
    clk_cfg_d = clk_cfg_q;
    ctl_cfg_d = ctl_cfg_q;
    limit_d   = limit_q;
    ena_d     = ena_q;
    if (wr_clk) clk_cfg_d = clk_cfg_t'(wdata[5:0]);
    if (wr_ctl) begin
      ctl_cfg_d.halt  = wdata[CTL_HALT_BIT];
      ctl_cfg_d.imode = wdata[CTL_IMODE_BIT];
      ctl_cfg_d.aux   = wdata[CTL_AUX_BIT];
    end
    if (wr_lim) limit_d = wdata;
    if (wr_ena) ena_d = {wdata[EVT_OVF_BIT], wdata[EVT_IVL_BIT]};
  end

  // status next state: new events survive a clearing read
  always_comb begin
    sts_d = rd_sts ? 2'b00 : sts_q;
    sts_d = sts_d | {evt_ovf, evt_ivl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cfg_q <= '0;
      ctl_cfg_q <= '{aux: 1'b0, imode: 1'b0, halt: 1'b1};
      limit_q   <= '0;
      count_q   <= '0;
      ena_q     <= '0;
      sts_q     <= '0;
    end else begin
      clk_cfg_q <= clk_cfg_d;
      ctl_cfg_q <= ctl_cfg_d;
      limit_q   <= limit_d;
      count_q   <= count_d;
      ena_q     <= ena_d;
      sts_q     <= sts_d;
    end
  end

  assign irq = |(sts_q & ena_q);

  always_comb begin
    rdata = '0;
    case (rd_kind)
      RK_CLK: rdata[5:0] = clk_cfg_q;
      RK_CTL: begin
        rdata[CTL_HALT_BIT]  = ctl_cfg_q.halt;
        rdata[CTL_IMODE_BIT] = ctl_cfg_q.imode;
        rdata[CTL_AUX_BIT]   = ctl_cfg_q.aux;
      end
      RK_VAL: rdata[CNT_W-1:0] = count_q;
      RK_LIM: rdata[CNT_W-1:0] = limit_q;
      RK_STS: begin
        rdata[EVT_IVL_BIT] = sts_q[0];
        rdata[EVT_OVF_BIT] = sts_q[1];
      end
      RK_ENA: begin
        rdata[EVT_IVL_BIT] = ena_q[0];
        rdata[EVT_OVF_BIT] = ena_q[1];
      end
      default: rdata = '0;
    endcase
  end

  // R3: halted count is frozen
  a_r3_hold_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_cfg_q.halt && !restart) |=> $stable(count_q));

  // R6: reset bit zeroes the count
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0));

  // R7: interval event wraps to zero and flags
  a_r7_interval_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ivl |=> (count_q == '0 && sts_q[0]));

  // R8: overflow wraps to zero and flags
  a_r8_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> (count_q == '0 && sts_q[1]));

  // R9: a read with no coincident event leaves status clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && !evt_ivl && !evt_ovf) |=> (sts_q == 2'b00));

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
  import itm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_kind_e         dec_kind;
  logic [CH_W-1:0]   dec_ch;
  logic              wr_req, rd_req;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];
  assign wr_req = bus_valid & bus_write;
  assign rd_req = bus_valid & ~bus_write;

  itm_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .kind  (dec_kind),
    .ch    (dec_ch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = (dec_kind != RK_NONE) && (dec_ch == CH_W'(g));

    itm_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .EXP_W(EXP_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_tick (ext_tick),
      .wr_clk   (wr_req & sel & (dec_kind == RK_CLK)),
      .wr_ctl   (wr_req & sel & (dec_kind == RK_CTL)),
      .wr_lim   (wr_req & sel & (dec_kind == RK_LIM)),
      .wr_ena   (wr_req & sel & (dec_kind == RK_ENA)),
      .rd_sts   (rd_req & sel & (dec_kind == RK_STS)),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .rd_kind  (dec_kind),
      .rdata    (ch_rdata[g]),
      .irq      (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_req && dec_kind != RK_NONE && dec_ch == CH_W'(i)) bus_rdata = ch_rdata[i];
    end
  end

  // R2: an unmapped read returns zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && dec_kind == RK_NONE) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  always #5 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // register bases (R2)
  localparam int B_CLK = 'h00, B_CTL = 'h0C, B_VAL = 'h18,
                 B_LIM = 'h24, B_STS = 'h54, B_ENA = 'h60;

  int checks = 0, fails = 0;
  int tick_phase = 0;
  string tag = "R1";

  // behavioural reference state
  int m_clk [NCH], m_ctl [NCH], m_lim [NCH], m_cnt [NCH];
  int m_ph [NCH], m_ena [NCH], m_sts [NCH];

  function automatic int addr_hit(int a, int base);
    for (int c = 0; c < NCH; c++) if (a == base + 4 * c) return c;
    return -1;
  endfunction

  function automatic int model_read(int a);
    if (addr_hit(a, B_CLK) >= 0) return m_clk[addr_hit(a, B_CLK)];
    if (addr_hit(a, B_CTL) >= 0) return m_ctl[addr_hit(a, B_CTL)];
    if (addr_hit(a, B_VAL) >= 0) return m_cnt[addr_hit(a, B_VAL)];
    if (addr_hit(a, B_LIM) >= 0) return m_lim[addr_hit(a, B_LIM)];
    if (addr_hit(a, B_STS) >= 0) return m_sts[addr_hit(a, B_STS)];
    if (addr_hit(a, B_ENA) >= 0) return m_ena[addr_hit(a, B_ENA)];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_clk[c] = 0; m_ctl[c] = 1; m_lim[c] = 0; m_cnt[c] = 0;
        m_ph[c] = 0; m_ena[c] = 0; m_sts[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit wr_ctl, restart, tick, stepped;
        int lim;
        wr_ctl  = bus_valid && bus_write && (int'(bus_addr) == B_CTL + 4 * c);
        restart = wr_ctl && bus_wdata[4];
        tick    = (m_ctl[c] & 1) == 0 && (((m_clk[c] >> 5) & 1) == 0 || ext_tick);
        lim     = (2 << ((m_clk[c] >> 1) & 15)) - 1;
        stepped = 0;
        if (tick) begin
          if (m_clk[c] & 1) begin
            if (m_ph[c] >= lim) begin stepped = 1; m_ph[c] = 0; end
            else m_ph[c]++;
          end else stepped = 1;
        end
        if ((m_clk[c] & 1) == 0 || restart) m_ph[c] = 0;
        if (bus_valid && !bus_write && (int'(bus_addr) == B_STS + 4 * c)) m_sts[c] = 0;
        if (restart) m_cnt[c] = 0;
        else if (stepped) begin
          if (m_ctl[c] & 2) begin
            if (m_cnt[c] >= m_lim[c]) begin m_cnt[c] = 0; m_sts[c] |= 1; end
            else m_cnt[c]++;
          end else begin
            if (m_cnt[c] == 'hFFFF) begin m_cnt[c] = 0; m_sts[c] |= 'h10; end
            else m_cnt[c]++;
          end
        end
        if (bus_valid && bus_write) begin
          if (int'(bus_addr) == B_CLK + 4 * c) m_clk[c] = int'(bus_wdata) & 'h3F;
          if (wr_ctl) m_ctl[c] = int'(bus_wdata) & 'h23;
          if (int'(bus_addr) == B_LIM + 4 * c) m_lim[c] = int'(bus_wdata) & 'hFFFF;
          if (int'(bus_addr) == B_ENA + 4 * c) m_ena[c] = int'(bus_wdata) & 'h11;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp_v);
    end
  endtask

  // one bus cycle; compares irq every cycle and read data on reads
  task automatic cyc(bit v, bit w, int a, int d);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = 8'(a); bus_wdata = 32'(d);
    ext_tick = (tick_phase % 3 == 0);
    tick_phase++;
    #1;
    for (int c = 0; c < NCH; c++)
      check((tag == "R1") ? "R1" : "R10", int'(irq[c]), int'(m_sts[c] & m_ena[c]) != 0, "irq");
    if (v && !w) check(tag, int'(bus_rdata), model_read(a), "read data");
  endtask

  task automatic wr(int a, int d); cyc(1, 1, a, d); endtask
  task automatic rd(int a); cyc(1, 0, a, 0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0); endtask

  bit done = 0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    tag = "R1";
    foreach (m_clk[c]) begin
      rd(B_CLK + 4 * c); rd(B_CTL + 4 * c); rd(B_VAL + 4 * c);
      rd(B_LIM + 4 * c); rd(B_STS + 4 * c); rd(B_ENA + 4 * c);
    end
    tag = "R2";
    rd('h30); rd('h26); rd('hFC);

    tag = "R3";
    wr(B_CTL, 'h00); idle(10); rd(B_VAL);
    wr(B_CTL, 'h01); idle(5); rd(B_VAL); rd(B_VAL);

    tag = "R4";
    wr(B_CLK, 'h05); wr(B_CTL, 'h10);
    for (int i = 0; i < 12; i++) begin idle(3); rd(B_VAL + 0); end

    tag = "R5";
    wr(B_CLK + 8, 'h20); wr(B_CTL + 8, 'h10);
    idle(20); rd(B_VAL + 8); rd(B_CLK + 8);
    wr(B_CLK + 8, 'h23);
    for (int i = 0; i < 8; i++) begin idle(4); rd(B_VAL + 8); end

    tag = "R6";
    wr(B_CTL, 'h01); idle(4); wr(B_CTL, 'h10);
    rd(B_VAL); rd(B_CTL); idle(6); rd(B_VAL);
    wr(B_CTL + 8, 'h23); rd(B_CTL + 8); idle(5); rd(B_VAL + 8);

    tag = "R7";
    wr(B_LIM + 4, 5); wr(B_ENA + 4, 'h01); wr(B_CLK + 4, 'h00);
    wr(B_CTL + 4, 'h12);
    for (int i = 0; i < 10; i++) begin idle(1); rd(B_VAL + 4); end
    rd(B_STS + 4); rd(B_STS + 4);

    tag = "R9";
    for (int i = 0; i < 30; i++) rd(B_STS + 4);

    tag = "R11";
    wr(B_VAL + 4, 'h1234); rd(B_VAL + 4);
    idle(7); wr(B_STS + 4, 'h11); rd(B_STS + 4);

    tag = "R10";
    wr(B_ENA + 4, 'h10); idle(15); rd(B_ENA + 4); rd(B_STS + 4);
    wr(B_ENA + 4, 'h11); idle(8); rd(B_STS + 4);

    tag = "R8";
    wr(B_CLK, 'h00); wr(B_ENA, 'h10); wr(B_CTL, 'h10);
    idle(65530); rd(B_VAL); idle(10); rd(B_STS); rd(B_STS); rd(B_VAL);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule